// File: doc/BRIEF.md
# Dual Phase Comparison Trip Logic

This block makes the trip decision for a line protection relay that compares the phase of a sequence current at both ends of the line. Two local square waves show the positive and the negative half-cycles of the local measurement. Two received channel levels carry the same information from the remote terminal. Each local wave is ANDed with its matching received level. When either product stays true for a qualifying time while the relay is armed, a latched trip output is set.

All inputs are synchronous, already digitised levels. Time is counted from a one-cycle tick enable, nominally 1 ms.

When the channel indication drops, both received levels are forced high at once, so the local waves alone can trip. A loss-of-channel alarm is raised. If the channel stays absent for a fixed number of ticks, both received levels are forced low and further tripping is blocked. When the channel returns, the clamp and the lockout clear immediately, the absence timer restarts from zero, and the alarm falls at the next tick.

Top module: `dpc_trip_logic`

## Requirements
- R1: With `chan_ok`=1 and `arm`=1, holding `loc_pos`=1 and `rx_pos`=1 sets `trip` once QUAL_TICKS (default 4) ticks have been sampled during the coincidence. It does not set after QUAL_TICKS-1 ticks.
- R2: The same holds for the negative path, `loc_neg` AND `rx_neg`, with the positive path inactive.
- R3: A coincidence that drops for even one clock cycle restarts its duration count from zero. A pattern made of stretches shorter than QUAL_TICKS ticks never trips, and neither does a local wave shifted by half a cycle against the received one.
- R4: `trip` is set only in a clock cycle where `arm` is 1. The duration counts keep running while `arm` is 0, so raising `arm` after a qualified coincidence sets `trip` on the next clock edge.
- R5: Once set, `trip` stays 1 whatever the other inputs do, until a clock edge with `rst_n`=0.
- R6: While `chan_ok`=0 and the block is not locked out, both received levels are treated as 1, so a local wave alone trips after QUAL_TICKS ticks.
- R7: After LOCK_TICKS (default 150) ticks with `chan_ok`=0, `lockout` goes to 1. It stays 0 after LOCK_TICKS-1 ticks. While `lockout`=1, both received levels are treated as 0 and `trip` cannot be set.
- R8: `chan_alarm` rises on the first clock edge with `chan_ok`=0. After `chan_ok` returns to 1, it falls on the first edge where `tick`=1.
- R9: When `chan_ok` returns to 1, `lockout` clears and the absence count restarts from zero. A later loss therefore takes a full LOCK_TICKS ticks again before lockout.
- R10: After reset, `trip`, `chan_alarm` and `lockout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the only way to clear trip |
| tick | input | 1 | One-cycle time-base enable, nominally 1 ms |
| loc_pos | input | 1 | Local square wave, high in the positive half-cycle |
| loc_neg | input | 1 | Local square wave, high in the negative half-cycle |
| rx_pos | input | 1 | Received trip-positive level |
| rx_neg | input | 1 | Received trip-negative level |
| arm | input | 1 | Fault-detector arming |
| chan_ok | input | 1 | Channel present (1) or lost (0) |
| trip | output | 1 | Latched trip command |
| chan_alarm | output | 1 | Loss-of-channel alarm |
| lockout | output | 1 | Trip path blocked after prolonged channel loss |

## Verification
An in-phase coincidence is applied on each path separately. The result is sampled one tick short of the threshold and again at the threshold, which tells an early trip from a late one and shows that each path works on its own. Two patterns must not trip: stretches interrupted for a single clock, and waves shifted by half a cycle. These distinguish a count that clears on every drop from one that only pauses. Arming is withheld and then supplied, to show that the counts ran on without it. A channel-loss sequence with the raw received levels at 0 tells a working clamp from none. The lockout is checked on both sides of LOCK_TICKS, both before and after a channel return, which separates a restarting absence timer from one that keeps its old value.

// File: rtl/dpc_pkg.sv
// Shared types for the dual phase comparison trip logic.
package dpc_pkg;
    // Condition of the communication channel as seen by the trip logic.
    typedef enum logic [1:0] {
        CH_PRESENT = 2'd0,
        CH_CLAMPED = 2'd1,
        CH_LOCKED  = 2'd2
    } chan_state_e;
endpackage

// File: rtl/dpc_chan_supervisor.sv
// Channel supervisor.
// Turns the raw received levels into effective levels, following the
// channel condition: pass-through while present, forced to 1 while lost,
// forced to 0 once lost for LOCK_TICKS ticks. Also drives the alarm.
// Assumes tick is a single-cycle enable and that all inputs are synchronous.
module dpc_chan_supervisor
    import dpc_pkg::*;
#(
    parameter int LOCK_TICKS = 150
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        chan_ok,
    input  logic        rx_pos_raw,
    input  logic        rx_neg_raw,
    output logic        rx_pos_eff,
    output logic        rx_neg_eff,
    output chan_state_e state,
    output logic        alarm
);
    localparam int LW = $clog2(LOCK_TICKS + 1);
    localparam logic [LW-1:0] LOCK_LIMIT = LW'(LOCK_TICKS);

    logic [LW-1:0] absent_cnt;

    // Count ticks of channel absence, saturating; restart when the channel returns.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_ok) begin
            absent_cnt <= '0;
        end else if (tick && absent_cnt < LOCK_LIMIT) begin
            absent_cnt <= absent_cnt + 1'b1;
        end
    end

    // Alarm sets on loss and clears on the first tick after the channel is back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm <= 1'b0;
        end else if (!chan_ok) begin
            alarm <= 1'b1;
        end else if (tick) begin
            alarm <= 1'b0;
        end
    end

    // Derive the channel condition from the live indication and the absence count.
    always_comb begin
        if (chan_ok)                       state = CH_PRESENT;
        else if (absent_cnt >= LOCK_LIMIT) state = CH_LOCKED;
        else                               state = CH_CLAMPED;
    end

    // Select the effective received levels for the current condition.
    always_comb begin
        unique case (state)
            CH_PRESENT: begin rx_pos_eff = rx_pos_raw; rx_neg_eff = rx_neg_raw; end
            CH_CLAMPED: begin rx_pos_eff = 1'b1;       rx_neg_eff = 1'b1;       end
            default:    begin rx_pos_eff = 1'b0;       rx_neg_eff = 1'b0;       end
        endcase
    end
endmodule

// File: rtl/dpc_coinc_timer.sv
// Coincidence duration timer for one half-cycle path.
// Forms local AND received, and counts ticks while the product stays true.
// Any cycle with the product false clears the count. qualified is high
// once QUAL_TICKS ticks have been counted. Assumes tick is a one-cycle enable.
module dpc_coinc_timer #(
    parameter int QUAL_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic loc_wave,
    input  logic rx_level,
    output logic qualified
);
    localparam int CW = $clog2(QUAL_TICKS + 1);
    localparam logic [CW-1:0] QUAL_LIMIT = CW'(QUAL_TICKS);

    logic          coinc;
    logic [CW-1:0] dur_cnt;

    // Coincidence of the local half-cycle with the matching received level.
    always_comb coinc = loc_wave & rx_level;

    // Duration count: clear on a broken coincidence, otherwise saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !coinc) begin
            dur_cnt <= '0;
        end else if (tick && dur_cnt < QUAL_LIMIT) begin
            dur_cnt <= dur_cnt + 1'b1;
        end
    end

    // Qualification flag for the trip latch.
    always_comb qualified = (dur_cnt >= QUAL_LIMIT);
endmodule

// File: rtl/dpc_trip_logic.sv
// Dual phase comparison trip logic (top).
// Two coincidence paths, each with its own duration timer, feed a trip latch
// that needs arming. A channel supervisor clamps and later locks out the
// received levels on loss of channel. The trip latch clears only on reset.
// Assumes synchronous digitised inputs and a single-cycle tick enable.
module dpc_trip_logic
    import dpc_pkg::*;
#(
    parameter int QUAL_TICKS = 4,
    parameter int LOCK_TICKS = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic loc_pos,
    input  logic loc_neg,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic arm,
    input  logic chan_ok,
    output logic trip,
    output logic chan_alarm,
    output logic lockout
);
    localparam int NPATH = 2;

    chan_state_e      ch_state;
    logic [NPATH-1:0] loc_vec;
    logic [NPATH-1:0] rx_eff;
    logic [NPATH-1:0] qual_vec;
    logic             trip_set;

    dpc_chan_supervisor #(.LOCK_TICKS(LOCK_TICKS)) u_sup (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .chan_ok    (chan_ok),
        .rx_pos_raw (rx_pos),
        .rx_neg_raw (rx_neg),
        .rx_pos_eff (rx_eff[0]),
        .rx_neg_eff (rx_eff[1]),
        .state      (ch_state),
        .alarm      (chan_alarm)
    );

    // Path 0 is the positive half-cycle, path 1 the negative one.
    always_comb loc_vec = {loc_neg, loc_pos};

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        dpc_coinc_timer #(.QUAL_TICKS(QUAL_TICKS)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .loc_wave  (loc_vec[p]),
            .rx_level  (rx_eff[p]),
            .qualified (qual_vec[p])
        );
    end

    // Lockout indication taken from the supervisor condition.
    always_comb lockout = (ch_state == CH_LOCKED);

    // Trip condition: armed, any path qualified, not locked out.
    always_comb trip_set = arm && (|qual_vec) && !lockout;

    // Trip latch, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip <= 1'b0;
        end else if (trip_set) begin
            trip <= 1'b1;
        end
    end
endmodule

// File: rtl/dpc_trip_logic_checker.sv
// Property checker for dpc_trip_logic, attached with bind.
// Relates the top-level ports over time; holds from reset onward.
module dpc_trip_logic_checker (
    input logic clk,
    input logic rst_n,
    input logic arm,
    input logic chan_ok,
    input logic tick,
    input logic trip,
    input logic chan_alarm,
    input logic lockout
);
    // R5: a set trip stays set until reset
    assert_trip_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> trip);

    // R4: trip only rises after a cycle with arming present
    assert_trip_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!trip && !arm) |=> !trip);

    // R7: no trip may be set while locked out
    assert_lock_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trip && lockout) |=> !trip);

    // R8: alarm follows a loss of channel on the next edge
    assert_alarm_on_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_ok |=> chan_alarm);

    // R8: with the channel present and no tick, the alarm does not fall
    assert_alarm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_alarm && !tick) |=> chan_alarm);

    // R9: lockout never shows while the channel is present
    assert_no_lock_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chan_ok |-> !lockout);
endmodule

bind dpc_trip_logic dpc_trip_logic_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .chan_ok    (chan_ok),
    .tick       (tick),
    .trip       (trip),
    .chan_alarm (chan_alarm),
    .lockout    (lockout)
);

// File: tb/tb_dpc_trip_logic.sv
// Directed bench for dpc_trip_logic: one task per scenario.
module tb_dpc_trip_logic;
    localparam int QUAL = 4;
    localparam int LOCK = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic loc_pos = 1'b0, loc_neg = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
    logic arm = 1'b0, chan_ok = 1'b1;
    logic trip, chan_alarm, lockout;

    int total = 0;
    int bad = 0;

    dpc_trip_logic #(.QUAL_TICKS(QUAL), .LOCK_TICKS(LOCK)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .loc_pos(loc_pos), .loc_neg(loc_neg), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .arm(arm), .chan_ok(chan_ok),
        .trip(trip), .chan_alarm(chan_alarm), .lockout(lockout)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    // Each tick: one-cycle pulse followed by four quiet cycles.
    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        loc_pos = 0; loc_neg = 0; rx_pos = 0; rx_neg = 0; arm = 0; chan_ok = 1; tick = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R10", "trip after reset", trip, 1'b0);
        check("R10", "alarm after reset", chan_alarm, 1'b0);
        check("R10", "lockout after reset", lockout, 1'b0);
    endtask

    task automatic t_pos_path();
        do_reset();
        arm = 1; loc_pos = 1; rx_pos = 1;
        do_tick(QUAL - 1);
        check("R1", "trip one tick short", trip, 1'b0);
        do_tick(1);
        check("R1", "trip at threshold", trip, 1'b1);
    endtask

    task automatic t_neg_path();
        do_reset();
        arm = 1; loc_neg = 1; rx_neg = 1;
        do_tick(QUAL - 1);
        check("R2", "trip one tick short", trip, 1'b0);
        do_tick(1);
        check("R2", "trip at threshold", trip, 1'b1);
    endtask

    task automatic t_broken_and_antiphase();
        do_reset();
        arm = 1; rx_pos = 1;
        for (int k = 0; k < 5; k++) begin
            loc_pos = 1; do_tick(QUAL - 1);
            @(negedge clk) loc_pos = 0;
            @(negedge clk);
        end
        check("R3", "interrupted coincidence", trip, 1'b0);
        for (int k = 0; k < 6; k++) begin
            loc_pos = 1; loc_neg = 0; rx_pos = 0; rx_neg = 1; do_tick(3);
            loc_pos = 0; loc_neg = 1; rx_pos = 1; rx_neg = 0; do_tick(3);
        end
        check("R3", "half-cycle shifted waves", trip, 1'b0);
    endtask

    task automatic t_arm_and_latch();
        do_reset();
        loc_pos = 1; rx_pos = 1; arm = 0;
        do_tick(QUAL + 2);
        check("R4", "no trip unarmed", trip, 1'b0);
        @(negedge clk) arm = 1;
        @(negedge clk);
        check("R4", "trip next edge after arming", trip, 1'b1);
        arm = 0; loc_pos = 0; rx_pos = 0; chan_ok = 0;
        do_tick(3);
        check("R5", "trip held", trip, 1'b1);
        chan_ok = 1;
        @(negedge clk) rst_n = 0;
        @(negedge clk) rst_n = 1;
        check("R5", "trip cleared by reset", trip, 1'b0);
    endtask

    task automatic t_clamp_trip();
        do_reset();
        arm = 1; loc_pos = 1; rx_pos = 0; rx_neg = 0;
        @(negedge clk) chan_ok = 0;
        @(negedge clk);
        check("R8", "alarm after loss", chan_alarm, 1'b1);
        do_tick(QUAL - 1);
        check("R6", "clamped, one tick short", trip, 1'b0);
        do_tick(1);
        check("R6", "local-only trip", trip, 1'b1);
    endtask

    task automatic t_lockout_and_return();
        do_reset();
        arm = 1; rx_pos = 0; rx_neg = 0;
        @(negedge clk) chan_ok = 0;
        do_tick(LOCK - 1);
        check("R7", "lockout one tick short", lockout, 1'b0);
        do_tick(1);
        check("R7", "lockout at limit", lockout, 1'b1);
        loc_pos = 1; loc_neg = 1;
        do_tick(QUAL + 2);
        check("R7", "no trip while locked", trip, 1'b0);
        loc_pos = 0; loc_neg = 0;
        @(negedge clk) chan_ok = 1;
        @(negedge clk);
        check("R9", "lockout cleared on return", lockout, 1'b0);
        check("R8", "alarm held until tick", chan_alarm, 1'b1);
        do_tick(1);
        check("R8", "alarm dropped after tick", chan_alarm, 1'b0);
        @(negedge clk) chan_ok = 0;
        do_tick(LOCK - 1);
        check("R9", "timer restarted, no lockout yet", lockout, 1'b0);
        do_tick(1);
        check("R9", "lockout after full window", lockout, 1'b1);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        t_reset_state();
        t_pos_path();
        t_neg_path();
        t_broken_and_antiphase();
        t_arm_and_latch();
        t_clamp_trip();
        t_lockout_and_return();
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end
endmodule